// File: doc/BRIEF.md
# Trigger Latency Buffer with Derandomizer

The block keeps a record of per-channel hit data for every bunch crossing. Each clock cycle is one crossing. Every cycle it writes the current data word, together with its 12-bit crossing number, into a circular buffer of 164 entries, so the history always reaches back further than the trigger latency. The latency is a run-time input in crossings. The typical setting is 160 crossings, which is 4 µs at 40 MHz.

When an accept pulse arrives, the controller looks back by the latency to find the triggered crossing. It then copies that crossing into a 48-entry derandomizing FIFO, and when a wider window is selected it also copies the one or two crossings that follow. Each stored record carries three further fields: the crossing number, the accepted-event number, and a flag that marks the final record of the event.

An event is stored whole or not at all. The event is dropped in two cases: the FIFO cannot take the whole window, or a previous window is still being copied. A drop raises a sticky flag and increments a saturating counter. The readout side sees the head of the FIFO directly and removes it with a one-cycle pop strobe.

The controller has two states:
- **IDLE**: waits for an accept.
- **FETCH**: copies the second and third crossings of a window.

It has three transitions:
- **IDLE→FETCH** on a stored accept with a window of two or three.
- **FETCH→FETCH** while crossings remain.
- **FETCH→IDLE** after the read of the last crossing.

A stored accept with a window of one, and any dropped accept, keep the controller in IDLE.

Top module: `trig_latency_buffer`

## Requirements
- R1: A stored accept sampled at edge t with effective latency L delivers first the data word that was sampled at edge t−L.
- R2: `win_sel` selects the number of consecutive crossings stored per accept: code 2 gives two, code 3 gives three, codes 0 and 1 give one. The records are stored oldest crossing first.
- R3: `out_last` is 1 on the final record of each event and 0 on every other record.
- R4: The crossing number is 12 bits and advances by one per cycle, wrapping at 4096. The crossing sampled at an edge where `bcr` is high is numbered 0, and the crossings after it are numbered 1, 2 and so on.
- R5: All records of one event carry the same event number. The event number advances by one per stored event. An event stored at an edge where `ecr` is high is numbered 0.
- R6: An accept is dropped whole when the FIFO occupancy, plus any record still in flight, plus the window length would exceed 48. A dropped accept stores nothing and sets `drop_flag`.
- R7: An accept that arrives while a two- or three-crossing window is still being copied is dropped and sets `drop_flag`.
- R8: `drop_cnt` (8 bits) counts dropped accepts and holds at 255.
- R9: The FIFO is first-in first-out, with the head visible whenever `out_valid` is 1. A pop while the FIFO is empty has no effect. `full` is 1 exactly when 48 records are held.
- R10: A latency of 0 acts as 1. A latency of 164 or more acts as 163.
- R11: Synchronous reset empties the FIFO and clears `drop_flag`, `drop_cnt`, the crossing counter and the event counter. `drop_flag` stays set until reset.
- R12: With an empty FIFO, the first record of an accept sampled at edge t becomes visible after edge t+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock; one cycle per crossing |
| rst | input | 1 | Synchronous reset, active high |
| bcr | input | 1 | Restarts crossing numbering at 0 |
| ecr | input | 1 | Restarts event numbering at 0 |
| acc | input | 1 | Trigger accept pulse |
| win_sel | input | 2 | Window length code |
| latency | input | 8 | Trigger latency in crossings |
| din | input | 240 | Hit data of the current crossing |
| pop | input | 1 | Removes the FIFO head |
| out_valid | output | 1 | FIFO head is valid |
| out_data | output | 240 | Hit data of the head record |
| out_bx | output | 12 | Crossing number of the head record |
| out_ev | output | 12 | Event number of the head record |
| out_last | output | 1 | Head record is the last record of its event |
| full | output | 1 | FIFO holds 48 records |
| drop_flag | output | 1 | Sticky flag for dropped accepts |
| drop_cnt | output | 8 | Saturating count of dropped accepts |

## Verification
An accept updates `drop_flag` and `drop_cnt` one edge after it is sampled. The first record of the window reaches the FIFO head one edge later still, and each further record of the window follows one cycle after the previous one. A pop changes the head one edge after the edge that samples it. The bench drives inputs and samples outputs on falling edges. It checks the head only after waiting the full window length plus a margin, and it probes the R12 timing at exactly the falling edges before and after the head becomes valid. Expected data and crossing numbers come from the bench's own count of rising edges and from its record of where `bcr` pulsed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        FS_IDLE,
        FS_FETCH
    } fetch_state_e;

    // window code to number of crossings
    function automatic logic [1:0] win_len(input logic [1:0] sel);
        case (sel)
            2'd2:    return 2'd2;
            2'd3:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/tlb_ring.sv
module tlb_ring #(
    parameter int W     = 252,
    parameter int DEPTH = 164,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_ptr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            wr_ptr <= '0;
        else if (wr_ptr == AW'(DEPTH - 1))
            wr_ptr <= '0;
        else
            wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= wr_data;
        if (rd_en)
            rd_data <= mem[rd_addr];
    end

    // R1: a lookup never targets the slot being overwritten
    p_rd_not_wr_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr != wr_ptr));

    // R1: lookups stay inside the ring
    p_rd_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr < AW'(DEPTH)));

endmodule

// File: rtl/tlb_fifo.sv
module tlb_fifo #(
    parameter int W     = 265,
    parameter int DEPTH = 48,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          valid,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_pop;

    assign do_pop = pop && (count != '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push)
                wp <= bump(wp);
            if (do_pop)
                rp <= bump(rp);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rp];
    assign valid = (count != '0);
    assign full  = (count == CW'(DEPTH));

    // R6: the controller never pushes into a full FIFO
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R9: a pop on an empty FIFO leaves it empty
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !valid && !push) |=> !valid);

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int DEPTH      = 164,
    parameter int FIFO_DEPTH = 48,
    parameter int DROP_W     = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [1:0]        win_sel,
    input  logic [AW-1:0]     latency,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [CW-1:0]     fifo_cnt,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              push,
    output logic              push_last,
    output logic              ev_store,
    output logic              drop_flag,
    output logic [DROP_W-1:0] drop_cnt
);

    fetch_state_e  state, state_n;
    logic [1:0]    remain, remain_n;
    logic [AW-1:0] next_ptr, next_ptr_n;
    logic          rd_last;
    logic          drop_now;
    logic [AW:0]   lat_eff;
    logic [AW:0]   base_sum;
    logic [AW:0]   start_w;
    logic [AW-1:0] start_addr;
    logic [1:0]    win_n;
    logic [CW+1:0] need;
    logic          room_ok;

    function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] a);
        return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
    endfunction

    // lookback address and room check
    always_comb begin
        if (latency == '0)
            lat_eff = (AW+1)'(1);
        else if ({1'b0, latency} >= (AW+1)'(DEPTH))
            lat_eff = (AW+1)'(DEPTH - 1);
        else
            lat_eff = {1'b0, latency};
        base_sum = {1'b0, wr_ptr} + (AW+1)'(DEPTH) - lat_eff;
        start_w  = (base_sum >= (AW+1)'(DEPTH)) ? base_sum - (AW+1)'(DEPTH) : base_sum;
        start_addr = start_w[AW-1:0];
        win_n   = win_len(win_sel);
        need    = (CW+2)'(fifo_cnt) + (CW+2)'(push) + (CW+2)'(win_n);
        room_ok = (need <= (CW+2)'(FIFO_DEPTH));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            remain    <= '0;
            next_ptr  <= '0;
            push      <= 1'b0;
            push_last <= 1'b0;
        end else begin
            state     <= state_n;
            remain    <= remain_n;
            next_ptr  <= next_ptr_n;
            push      <= rd_en;
            push_last <= rd_last;
        end
    end

    // next state and outputs
    always_comb begin
        state_n    = state;
        remain_n   = remain;
        next_ptr_n = next_ptr;
        rd_en      = 1'b0;
        rd_addr    = start_addr;
        rd_last    = 1'b0;
        ev_store   = 1'b0;
        drop_now   = 1'b0;
        unique case (state)
            FS_IDLE: begin
                if (acc) begin
                    if (room_ok) begin
                        rd_en      = 1'b1;
                        ev_store   = 1'b1;
                        next_ptr_n = ring_inc(start_addr);
                        if (win_n == 2'd1) begin
                            rd_last = 1'b1;
                        end else begin
                            state_n  = FS_FETCH;
                            remain_n = win_n - 2'd1;
                        end
                    end else begin
                        drop_now = 1'b1;
                    end
                end
            end
            FS_FETCH: begin
                rd_en      = 1'b1;
                rd_addr    = next_ptr;
                next_ptr_n = ring_inc(next_ptr);
                remain_n   = remain - 2'd1;
                if (remain == 2'd1) begin
                    rd_last = 1'b1;
                    state_n = FS_IDLE;
                end
                drop_now = acc;
            end
        endcase
    end

    // drop bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            drop_flag <= 1'b0;
            drop_cnt  <= '0;
        end else if (drop_now) begin
            drop_flag <= 1'b1;
            if (drop_cnt != '1)
                drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // R7: an accept during a window copy is refused
    p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FETCH && acc) |=> drop_flag);

    // R6: the drop flag is sticky
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        drop_flag |=> drop_flag);

    // R8: the drop counter holds at its maximum
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == '1) |=> (drop_cnt == '1));

    // R3: a window copy always ends with a last-marked push
    p_fetch_end_r3: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FETCH && remain == 2'd1) |=> (push && push_last));

endmodule

// File: rtl/trig_latency_buffer.sv
module trig_latency_buffer #(
    parameter int DATA_W     = 240,
    parameter int RING_DEPTH = 164,
    parameter int FIFO_DEPTH = 48,
    parameter int BX_W       = 12,
    parameter int EV_W       = 12,
    parameter int DROP_W     = 8,
    localparam int AW        = $clog2(RING_DEPTH),
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int RW        = BX_W + DATA_W,
    localparam int FW        = 1 + EV_W + BX_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bcr,
    input  logic              ecr,
    input  logic              acc,
    input  logic [1:0]        win_sel,
    input  logic [AW-1:0]     latency,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [BX_W-1:0]   out_bx,
    output logic [EV_W-1:0]   out_ev,
    output logic              out_last,
    output logic              full,
    output logic              drop_flag,
    output logic [DROP_W-1:0] drop_cnt
);

    logic [BX_W-1:0] bx_cnt, bx_tag;
    logic [EV_W-1:0] ev_cnt, ev_tag, ev_hold;
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_addr;
    logic            rd_en;
    logic [RW-1:0]   rd_data;
    logic            push, push_last, ev_store;
    logic [CW-1:0]   fifo_cnt;
    logic [FW-1:0]   head;

    // crossing and event numbering
    assign bx_tag = bcr ? '0 : bx_cnt;
    assign ev_tag = ecr ? '0 : ev_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bx_cnt  <= '0;
            ev_cnt  <= '0;
            ev_hold <= '0;
        end else begin
            bx_cnt <= bx_tag + 1'b1;
            if (ev_store) begin
                ev_cnt  <= ev_tag + 1'b1;
                ev_hold <= ev_tag;
            end else begin
                ev_cnt <= ev_tag;
            end
        end
    end

    tlb_ring #(
        .W     (RW),
        .DEPTH (RING_DEPTH)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_data ({bx_tag, din}),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_ptr  (wr_ptr),
        .rd_data (rd_data)
    );

    tlb_ctrl #(
        .DEPTH      (RING_DEPTH),
        .FIFO_DEPTH (FIFO_DEPTH),
        .DROP_W     (DROP_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .win_sel   (win_sel),
        .latency   (latency),
        .wr_ptr    (wr_ptr),
        .fifo_cnt  (fifo_cnt),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .push      (push),
        .push_last (push_last),
        .ev_store  (ev_store),
        .drop_flag (drop_flag),
        .drop_cnt  (drop_cnt)
    );

    tlb_fifo #(
        .W     (FW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data ({push_last, ev_hold, rd_data}),
        .pop       (pop),
        .head      (head),
        .valid     (out_valid),
        .count     (fifo_cnt),
        .full      (full)
    );

    assign out_last = head[FW-1];
    assign out_ev   = head[FW-2 -: EV_W];
    assign out_bx   = head[DATA_W +: BX_W];
    assign out_data = head[DATA_W-1:0];

endmodule

// File: tb/trig_latency_buffer_bench.sv
module trig_latency_buffer_bench;

    localparam int DW = 240;

    logic          clk = 1'b0;
    logic          rst, bcr, ecr, acc, pop;
    logic [1:0]    win_sel;
    logic [7:0]    latency;
    logic [DW-1:0] din;
    logic          out_valid, out_last, full, drop_flag;
    logic [DW-1:0] out_data;
    logic [11:0]   out_bx, out_ev;
    logic [7:0]    drop_cnt;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int bcr_old = 0, bcr_new = 0;
    int ev_m = 0, drops_m = 0;
    int q_d[$];
    int q_bx[$];
    int q_ev[$];
    int q_last[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign din = {15{cyc[15:0]}};

    trig_latency_buffer u_trig_latency_buffer (
        .clk(clk), .rst(rst), .bcr(bcr), .ecr(ecr), .acc(acc),
        .win_sel(win_sel), .latency(latency), .din(din), .pop(pop),
        .out_valid(out_valid), .out_data(out_data), .out_bx(out_bx),
        .out_ev(out_ev), .out_last(out_last), .full(full),
        .drop_flag(drop_flag), .drop_cnt(drop_cnt)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bx_of(input int k);
        if (k >= bcr_new) return (k - bcr_new) & 4095;
        return (k - bcr_old) & 4095;
    endfunction

    function automatic int eff_lat(input int l);
        if (l == 0) return 1;
        if (l >= 164) return 163;
        return l;
    endfunction

    function automatic int wlen(input logic [1:0] w);
        if (w == 2'd3) return 3;
        if (w == 2'd2) return 2;
        return 1;
    endfunction

    task automatic expect_event(input int c, input logic [1:0] w, input int lat);
        int n = wlen(w);
        int l = eff_lat(lat);
        for (int k = 0; k < n; k++) begin
            q_d.push_back((c - l + k) & 16'hffff);
            q_bx.push_back(bx_of(c - l + k));
            q_ev.push_back(ev_m & 4095);
            q_last.push_back(k == n - 1 ? 1 : 0);
        end
        ev_m++;
    endtask

    // one accept pulse followed by idle cycles
    task automatic pulse_acc(input logic [1:0] w, input int lat, input bit store, input bit with_ecr);
        int c;
        @(negedge clk);
        win_sel = w;
        latency = 8'(lat);
        acc = 1'b1;
        ecr = with_ecr;
        c = cyc;
        @(negedge clk);
        acc = 1'b0;
        ecr = 1'b0;
        if (with_ecr) ev_m = 0;
        if (store) expect_event(c, w, lat);
        else if (drops_m < 255) drops_m++;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input string req);
        while (q_d.size() > 0) begin
            chk(req, "valid", longint'(out_valid), 1);
            chk(req, "data", longint'({out_data[DW-1 -: 16], out_data[15:0]}),
                longint'({q_d[0][15:0], q_d[0][15:0]}));
            chk(req, "bx", longint'(out_bx), longint'(q_bx[0]));
            chk(req, "ev", longint'(out_ev), longint'(q_ev[0]));
            chk(req, "last", longint'(out_last), longint'(q_last[0]));
            void'(q_d.pop_front());
            void'(q_bx.pop_front());
            void'(q_ev.pop_front());
            void'(q_last.pop_front());
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        chk(req, "empty after drain", longint'(out_valid), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; bcr = 1'b0; ecr = 1'b0; acc = 1'b0; pop = 1'b0;
        win_sel = 2'd0; latency = 8'd160;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bcr = 1'b1;
        bcr_new = cyc; bcr_old = cyc;
        @(negedge clk);
        bcr = 1'b0;
        chk("R11", "out_valid", longint'(out_valid), 0);
        chk("R11", "full", longint'(full), 0);
        chk("R11", "drop_flag", longint'(drop_flag), 0);
        chk("R11", "drop_cnt", longint'(drop_cnt), 0);
        repeat (200) @(negedge clk);
    endtask

    task automatic t_single_timing();
        int c;
        @(negedge clk);
        win_sel = 2'd0; latency = 8'd160; acc = 1'b1; c = cyc;
        @(negedge clk);
        acc = 1'b0;
        chk("R12", "valid one edge after accept", longint'(out_valid), 0);
        @(negedge clk);
        chk("R12", "valid two edges after accept", longint'(out_valid), 1);
        expect_event(c, 2'd0, 160);
        drain("R1");
    endtask

    task automatic t_windows();
        pulse_acc(2'd3, 20, 1'b1, 1'b0);
        drain("R2");
        pulse_acc(2'd2, 100, 1'b1, 1'b0);
        drain("R3");
        pulse_acc(2'd1, 57, 1'b1, 1'b0);
        drain("R2");
    endtask

    task automatic t_bcr();
        @(negedge clk);
        bcr = 1'b1;
        bcr_old = bcr_new;
        bcr_new = cyc;
        @(negedge clk);
        bcr = 1'b0;
        // window spans the crossing before, at and after the restart
        pulse_acc(2'd3, 3, 1'b1, 1'b0);
        drain("R4");
    endtask

    task automatic t_ecr();
        pulse_acc(2'd2, 40, 1'b1, 1'b1);
        pulse_acc(2'd1, 41, 1'b1, 1'b0);
        drain("R5");
    endtask

    task automatic t_pop_empty();
        @(negedge clk);
        pop = 1'b1;
        repeat (2) @(negedge clk);
        pop = 1'b0;
        chk("R9", "valid after empty pops", longint'(out_valid), 0);
        pulse_acc(2'd1, 12, 1'b1, 1'b0);
        drain("R9");
    endtask

    task automatic t_lat_clamp();
        pulse_acc(2'd1, 0, 1'b1, 1'b0);
        drain("R10");
        pulse_acc(2'd1, 200, 1'b1, 1'b0);
        drain("R10");
    endtask

    task automatic t_busy();
        int c;
        @(negedge clk);
        win_sel = 2'd3; latency = 8'd30; acc = 1'b1; c = cyc;
        @(negedge clk);
        @(negedge clk);
        acc = 1'b0;
        expect_event(c, 2'd3, 30);
        drops_m++;
        repeat (4) @(negedge clk);
        chk("R7", "drop_flag", longint'(drop_flag), 1);
        chk("R7", "drop_cnt", longint'(drop_cnt), longint'(drops_m));
        drain("R7");
    endtask

    task automatic t_full_sat();
        for (int i = 0; i < 15; i++) pulse_acc(2'd3, 10, 1'b1, 1'b0);
        pulse_acc(2'd1, 10, 1'b1, 1'b0);
        chk("R9", "not full at 46", longint'(full), 0);
        pulse_acc(2'd3, 10, 1'b0, 1'b0);
        chk("R6", "drop_cnt after no-room", longint'(drop_cnt), longint'(drops_m));
        pulse_acc(2'd2, 10, 1'b1, 1'b0);
        chk("R9", "full at 48", longint'(full), 1);
        pulse_acc(2'd1, 10, 1'b0, 1'b0);
        chk("R6", "drop_cnt when full", longint'(drop_cnt), longint'(drops_m));
        for (int i = 0; i < 260; i++) pulse_acc(2'd1, 10, 1'b0, 1'b0);
        chk("R8", "drop_cnt saturated", longint'(drop_cnt), 255);
        chk("R11", "drop_flag sticky", longint'(drop_flag), 1);
        drain("R6");
        chk("R9", "not full after drain", longint'(full), 0);
    endtask

    initial begin
        t_reset();
        t_single_timing();
        t_windows();
        t_bcr();
        t_ecr();
        t_pop_empty();
        t_lat_clamp();
        t_busy();
        t_full_sat();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule